// File: doc/BRIEF.md
# Interrupt distributor register bank

This block is the register-facing half of a small interrupt controller. It keeps the state of every interrupt source: an enable bit, a pending bit, a priority byte, a byte of target CPUs and two trigger-configuration bits. It also keeps one global switch that lets interrupts through to the CPU side, and a read-only word that reports how many sources exist. Software reaches all of this over a plain 32-bit word bus. Writes take effect on the clock edge that samples the strobe. Read data comes back one cycle after the read strobe.

Raw interrupt lines come in one per source. Each line is qualified by its polarity and by its trigger mode, level or edge. The block drives a vector of sources that are pending and enabled, gated by the global switch. It also drives one summary wire per CPU, which is high when any qualified source names that CPU in its target byte. A CPU interface reports a taken interrupt on the acknowledge port, and that clears a latched edge. Software can raise sources 0 to 15 by writing a software-interrupt word.

The number of sources is a parameter, NUM_SRC, and must be a multiple of 32 up to 512. NUM_CPU sets the number of CPUs, up to 8.

Top module: `dist_regbank`

## Requirements
- R1: Word address 0x001 is read-only. Bits [4:0] read N, where NUM_SRC = 32*(N+1). Bits [31:5] read 0.
- R2: Enable bits are written through set-enable words at 0x040+w and clear-enable words at 0x060+w. Bit i is source 32*w+i. A 1 sets or clears that bit and a 0 leaves it alone. Both addresses read the current enable bits, and all enables reset to 0.
- R3: Pending state is written through set-pending words at 0x080+w and clear-pending words at 0x0A0+w, with the same bit mapping and the same write-one rule. Both addresses read the effective pending state.
- R4: Priority words at 0x100+w and target words at 0x180+w hold one byte per source, with source 4*w+k in bits [8k+7:8k]. They read back as written, and they reset to 0.
- R5: Configuration words at 0x200+w hold source 16*w+j in bits [2j+1:2j]. In each pair, bit 0 is polarity (1 active high, 0 active low) and bit 1 is trigger (1 edge, 0 level). The reset value is 0.
- R6: Bit 0 of the control word at 0x000 is the global distribution enable, and it resets to 0. While it is 0, irq_req and cpu_hit are all zero.
- R7: A level-triggered source is pending in the same cycle that its input sits at the active level. It stops being pending when the input goes inactive, unless a pending bit has been latched.
- R8: An active edge on an edge-triggered source latches pending at the next clock edge. A rising edge is active for polarity high and a falling edge for polarity low. The latch holds until a clear-pending write or an acknowledge (ack_valid with ack_id) removes it. A new edge in the same cycle as a clear or acknowledge keeps the source pending.
- R9: A write to 0x3C0 sets pending for the source ID in bits [3:0] when any of bits [16+NUM_CPU-1:16] is 1. With none of those bits set it has no effect. The address reads 0.
- R10: cpu_hit[c] is 1 when at least one source with irq_req high has bit c of its target byte set.
- R11: Read data appears on bus_rdata one cycle after bus_re and holds until the next read. Unimplemented addresses, including enable, pending, byte or configuration words beyond NUM_SRC, read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Single-cycle write strobe |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | 10 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after bus_re |
| irq_in | input | NUM_SRC | Raw interrupt lines, one per source |
| ack_valid | input | 1 | CPU interface acknowledges an interrupt |
| ack_id | input | $clog2(NUM_SRC) | Source being acknowledged |
| irq_req | output | NUM_SRC | Per source: pending and enabled and distribution on |
| cpu_hit | output | NUM_CPU | Per CPU: some qualified source targets this CPU |

## Verification
The qualification path is tested with four kinds of input:
- a level source held high and then dropped, which tells combinational level following from a latched bit;
- a single-cycle rising pulse on an active-high edge source, which has to survive after the line falls and is then removed once by clear-pending and once by acknowledge;
- a falling step on an active-low edge source, sampled before and after the clock edge, which pins the one-cycle latch timing;
- a pulse landing in the same cycle as a clear, which shows that the set takes priority.

Software interrupts are sent three ways: with a valid CPU bit, with no target bits, and with a bit just above the CPU count. Only the first may raise pending. Routing is checked by giving a single pending source a single target bit and watching the distribution switch turn the result off again.

// File: rtl/dist_pkg.sv
`timescale 1ns/1ps
package dist_pkg;
  localparam int ADDR_W = 10;

  typedef enum logic [3:0] {
    RG_NONE, RG_CTRL, RG_TYPE, RG_SETEN, RG_CLREN, RG_SETPD, RG_CLRPD,
    RG_PRIO, RG_TGT, RG_CFG, RG_SWI
  } reg_sel_e;

  typedef struct packed {
    reg_sel_e   sel;
    logic [6:0] idx;
  } reg_hit_t;

  // Map a word address onto a register group and a word index within it.
  function automatic reg_hit_t decode_addr(input logic [ADDR_W-1:0] a, input int nsrc);
    reg_hit_t h;
    h.sel = RG_NONE;
    h.idx = '0;
    if (a == 10'h000) h.sel = RG_CTRL;
    else if (a == 10'h001) h.sel = RG_TYPE;
    else if (a == 10'h3C0) h.sel = RG_SWI;
    else if (a[9:6] == 4'b0001) begin
      h.idx = {2'b00, a[4:0]};
      if (int'(a[4:0]) < nsrc / 32) h.sel = a[5] ? RG_CLREN : RG_SETEN;
    end else if (a[9:6] == 4'b0010) begin
      h.idx = {2'b00, a[4:0]};
      if (int'(a[4:0]) < nsrc / 32) h.sel = a[5] ? RG_CLRPD : RG_SETPD;
    end else if (a[9:8] == 2'b01) begin
      h.idx = a[6:0];
      if (int'(a[6:0]) < nsrc / 4) h.sel = a[7] ? RG_TGT : RG_PRIO;
    end else if (a[9:7] == 3'b100) begin
      h.idx = a[6:0];
      if (int'(a[6:0]) < nsrc / 16) h.sel = RG_CFG;
    end
    return h;
  endfunction

  // Coded source count: NUM_SRC = 32*(code+1).
  function automatic logic [4:0] type_code(input int nsrc);
    return 5'(nsrc / 32 - 1);
  endfunction

  // Input qualified by polarity: 1 means the line is at its active level.
  function automatic logic at_active(input logic pol_high, input logic line);
    return pol_high ? line : ~line;
  endfunction
endpackage

// File: rtl/dist_src_bank.sv
`timescale 1ns/1ps
module dist_src_bank
  import dist_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   irq_in,
  input  logic [NUM_SRC-1:0]   en_set,
  input  logic [NUM_SRC-1:0]   en_clr,
  input  logic [NUM_SRC-1:0]   pd_set,
  input  logic [NUM_SRC-1:0]   pd_clr,
  input  logic [NUM_SRC-1:0]   cfg_we,
  input  logic [2*NUM_SRC-1:0] cfg_wval,
  output logic [NUM_SRC-1:0]   en_q,
  output logic [2*NUM_SRC-1:0] cfg_q,
  output logic [NUM_SRC-1:0]   pend_eff,
  output logic [NUM_SRC-1:0]   edge_evt
);
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic prev_in;
    logic pend_q;
    logic act_now;
    logic act_prev;

    assign act_now     = at_active(cfg_q[2*s], irq_in[s]);
    assign act_prev    = at_active(cfg_q[2*s], prev_in);
    assign edge_evt[s] = cfg_q[2*s+1] & act_now & ~act_prev;
    assign pend_eff[s] = pend_q | (~cfg_q[2*s+1] & act_now);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_q[s]          <= 1'b0;
        cfg_q[2*s +: 2]  <= 2'b00;
        prev_in          <= 1'b0;
        pend_q           <= 1'b0;
      end else begin
        prev_in <= irq_in[s];
        if (en_set[s])      en_q[s] <= 1'b1;
        else if (en_clr[s]) en_q[s] <= 1'b0;
        if (cfg_we[s]) cfg_q[2*s +: 2] <= cfg_wval[2*s +: 2];
        // A new set event outranks a clear in the same cycle.
        if (edge_evt[s] || pd_set[s]) pend_q <= 1'b1;
        else if (pd_clr[s])           pend_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dist_byte_bank.sv
`timescale 1ns/1ps
module dist_byte_bank #(
  parameter int NUM_SRC = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [6:0]           widx,
  input  logic [31:0]          wdata,
  output logic [8*NUM_SRC-1:0] bytes_q
);
  localparam int NWORD = NUM_SRC / 4;

  for (genvar w = 0; w < NWORD; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)                        bytes_q[32*w +: 32] <= '0;
      else if (we && widx == 7'(w))      bytes_q[32*w +: 32] <= wdata;
    end
  end
endmodule

// File: rtl/dist_regbank.sv
`timescale 1ns/1ps
module dist_regbank
  import dist_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int NUM_CPU = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_we,
  input  logic                       bus_re,
  input  logic [9:0]                 bus_addr,
  input  logic [31:0]                bus_wdata,
  output logic [31:0]                bus_rdata,
  input  logic [NUM_SRC-1:0]         irq_in,
  input  logic                       ack_valid,
  input  logic [$clog2(NUM_SRC)-1:0] ack_id,
  output logic [NUM_SRC-1:0]         irq_req,
  output logic [NUM_CPU-1:0]         cpu_hit
);
  localparam int NW_BIT  = NUM_SRC / 32;
  localparam int NW_CFG  = NUM_SRC / 16;
  localparam int NW_BYTE = NUM_SRC / 4;

  reg_hit_t hit;
  logic [NUM_SRC-1:0]   word_mask, en_set, en_clr, pd_set, pd_clr, swi_set, ack_vec;
  logic [NUM_SRC-1:0]   cfg_we;
  logic [2*NUM_SRC-1:0] cfg_wval;
  logic [NUM_SRC-1:0]   en_q, pend_eff, edge_evt;
  logic [2*NUM_SRC-1:0] cfg_q;
  logic [8*NUM_SRC-1:0] prio_q, tgt_q;
  logic                 dist_en;
  logic [31:0]          rd_next;

  assign hit = decode_addr(bus_addr, NUM_SRC);

  // Write-one masks for the bit-per-source groups.
  always_comb begin
    word_mask = '0;
    for (int w = 0; w < NW_BIT; w++)
      if (hit.idx == 7'(w)) word_mask[32*w +: 32] = bus_wdata;
    swi_set = '0;
    if (bus_we && hit.sel == RG_SWI && |bus_wdata[16 +: NUM_CPU])
      swi_set = NUM_SRC'(1) << bus_wdata[3:0];
    ack_vec = ack_valid ? (NUM_SRC'(1) << ack_id) : '0;
    en_set  = (bus_we && hit.sel == RG_SETEN) ? word_mask : '0;
    en_clr  = (bus_we && hit.sel == RG_CLREN) ? word_mask : '0;
    pd_set  = ((bus_we && hit.sel == RG_SETPD) ? word_mask : '0) | swi_set;
    pd_clr  = ((bus_we && hit.sel == RG_CLRPD) ? word_mask : '0) | ack_vec;
    for (int s = 0; s < NUM_SRC; s++) begin
      cfg_we[s]          = bus_we && hit.sel == RG_CFG && hit.idx == 7'(s / 16);
      cfg_wval[2*s +: 2] = bus_wdata[2*(s % 16) +: 2];
    end
  end

  dist_src_bank #(.NUM_SRC(NUM_SRC)) u_src (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .en_set(en_set), .en_clr(en_clr), .pd_set(pd_set), .pd_clr(pd_clr),
    .cfg_we(cfg_we), .cfg_wval(cfg_wval),
    .en_q(en_q), .cfg_q(cfg_q), .pend_eff(pend_eff), .edge_evt(edge_evt)
  );

  dist_byte_bank #(.NUM_SRC(NUM_SRC)) u_prio (
    .clk(clk), .rst_n(rst_n), .we(bus_we && hit.sel == RG_PRIO),
    .widx(hit.idx), .wdata(bus_wdata), .bytes_q(prio_q)
  );

  dist_byte_bank #(.NUM_SRC(NUM_SRC)) u_tgt (
    .clk(clk), .rst_n(rst_n), .we(bus_we && hit.sel == RG_TGT),
    .widx(hit.idx), .wdata(bus_wdata), .bytes_q(tgt_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                          dist_en <= 1'b0;
    else if (bus_we && hit.sel == RG_CTRL) dist_en <= bus_wdata[0];
  end

  assign irq_req = pend_eff & en_q & {NUM_SRC{dist_en}};

  always_comb begin
    cpu_hit = '0;
    for (int c = 0; c < NUM_CPU; c++)
      for (int s = 0; s < NUM_SRC; s++)
        cpu_hit[c] = cpu_hit[c] | (irq_req[s] & tgt_q[8*s+c]);
  end

  // Read multiplexer, registered for one-cycle latency.
  always_comb begin
    rd_next = '0;
    case (hit.sel)
      RG_CTRL: rd_next = {31'b0, dist_en};
      RG_TYPE: rd_next = {27'b0, type_code(NUM_SRC)};
      RG_SETEN, RG_CLREN:
        for (int w = 0; w < NW_BIT; w++)
          if (hit.idx == 7'(w)) rd_next = en_q[32*w +: 32];
      RG_SETPD, RG_CLRPD:
        for (int w = 0; w < NW_BIT; w++)
          if (hit.idx == 7'(w)) rd_next = pend_eff[32*w +: 32];
      RG_PRIO:
        for (int w = 0; w < NW_BYTE; w++)
          if (hit.idx == 7'(w)) rd_next = prio_q[32*w +: 32];
      RG_TGT:
        for (int w = 0; w < NW_BYTE; w++)
          if (hit.idx == 7'(w)) rd_next = tgt_q[32*w +: 32];
      RG_CFG:
        for (int w = 0; w < NW_CFG; w++)
          if (hit.idx == 7'(w)) rd_next = cfg_q[32*w +: 32];
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_next;
  end
endmodule

// File: rtl/dist_regbank_chk.sv
`timescale 1ns/1ps
module dist_regbank_chk #(
  parameter int NUM_SRC = 64,
  parameter int NUM_CPU = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_we,
  input logic               bus_re,
  input logic [9:0]         bus_addr,
  input logic [31:0]        bus_wdata,
  input logic [31:0]        bus_rdata,
  input logic [NUM_SRC-1:0] irq_req,
  input logic [NUM_CPU-1:0] cpu_hit,
  input logic [NUM_SRC-1:0] en_q,
  input logic [NUM_SRC-1:0] pend_eff,
  input logic [NUM_SRC-1:0] edge_evt
);
  p_type_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re && bus_addr == 10'h001 |=>
      (32 * (int'(bus_rdata[4:0]) + 1) == NUM_SRC) && (bus_rdata[31:5] == '0));

  p_set_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == 10'h040 |=>
      ((en_q[31:0] & $past(bus_wdata)) == $past(bus_wdata)) &&
      ((en_q[31:0] & ~$past(bus_wdata)) == ($past(en_q[31:0]) & ~$past(bus_wdata))));

  p_clr_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == 10'h060 |=> (en_q[31:0] & $past(bus_wdata)) == '0);

  p_gate_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == 10'h000 && !bus_wdata[0] |=> (irq_req == '0) && (cpu_hit == '0));

  p_edge_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    |edge_evt |=> (pend_eff & $past(edge_evt)) == $past(edge_evt));

  p_swi_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == 10'h3C0 && |bus_wdata[16 +: NUM_CPU] |=>
      ((pend_eff >> $past(bus_wdata[3:0])) & NUM_SRC'(1)) != '0);

  p_unimpl_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re && bus_addr == 10'h3FF |=> bus_rdata == '0);
endmodule

bind dist_regbank dist_regbank_chk #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_chk (.*);

// File: tb/dist_regbank_tb.sv
`timescale 1ns/1ps
module dist_regbank_tb;
  localparam int NUM_SRC = 64;
  localparam int NUM_CPU = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_we = 1'b0, bus_re = 1'b0;
  logic [9:0]        bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [NUM_SRC-1:0] irq_in = '1;
  logic              ack_valid = 1'b0;
  logic [5:0]        ack_id = '0;
  logic [NUM_SRC-1:0] irq_req;
  logic [NUM_CPU-1:0] cpu_hit;

  int  n_chk = 0, n_bad = 0;
  bit  done = 1'b0;
  logic [31:0] rv;

  always #4 clk = ~clk;

  dist_regbank #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_in(irq_in), .ack_valid(ack_valid), .ack_id(ack_id),
    .irq_req(irq_req), .cpu_hit(cpu_hit)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk); bus_re = 1'b1; bus_addr = a;
    @(negedge clk); bus_re = 1'b0; d = bus_rdata;
  endtask

  task automatic t_reset;
    rd(10'h000, rv); chk("R6 control reset", rv, 0);
    rd(10'h001, rv); chk("R1 type code for 64 sources", rv, 1);
    rd(10'h100, rv); chk("R4 priority reset", rv, 0);
    rd(10'h200, rv); chk("R5 config reset", rv, 0);
    rd(10'h040, rv); chk("R2 enable reset", rv, 0);
    chk("R6 irq_req after reset", irq_req, 0);
  endtask

  task automatic t_enable;
    wr(10'h040, 32'h0000_00F0);
    rd(10'h040, rv); chk("R2 set-enable readback", rv, 32'hF0);
    rd(10'h060, rv); chk("R2 clear-enable address reads enables", rv, 32'hF0);
    wr(10'h040, 32'h0);
    rd(10'h040, rv); chk("R2 zero write to set-enable ignored", rv, 32'hF0);
    wr(10'h060, 32'h0000_0030);
    rd(10'h040, rv); chk("R2 clear-enable clears ones only", rv, 32'hC0);
    wr(10'h041, 32'h8000_0001);
    rd(10'h041, rv); chk("R2 second enable word", rv, 32'h8000_0001);
    wr(10'h060, 32'hFFFF_FFFF);
    wr(10'h061, 32'hFFFF_FFFF);
    rd(10'h041, rv); chk("R2 clear all enables", rv, 0);
  endtask

  task automatic t_bytes;
    wr(10'h103, 32'h4433_2211);
    rd(10'h103, rv); chk("R4 priority word readback", rv, 32'h4433_2211);
    rd(10'h102, rv); chk("R4 neighbouring priority word untouched", rv, 0);
    wr(10'h182, 32'hA5C3_0F01);
    rd(10'h182, rv); chk("R4 target word readback", rv, 32'hA5C3_0F01);
  endtask

  task automatic t_cfg;
    @(negedge clk); irq_in[40] = 1'b0; irq_in[50] = 1'b1; irq_in[51] = 1'b1;
    wr(10'h202, 32'h0001_0000);   // source 40: level, active high
    wr(10'h203, 32'h0000_00B0);   // source 50: edge high, source 51: edge low
    rd(10'h202, rv); chk("R5 config word 2 readback", rv, 32'h0001_0000);
    rd(10'h203, rv); chk("R5 config word 3 readback", rv, 32'h0000_00B0);
  endtask

  task automatic t_level;
    wr(10'h041, 32'h0000_0100);
    @(negedge clk); irq_in[40] = 1'b1; #1;
    chk("R6 distribution off blocks request", irq_req[40], 0);
    wr(10'h000, 32'h1);
    #1; chk("R7 level high requests", irq_req[40], 1);
    rd(10'h081, rv); chk("R3 level source reads pending", rv, 32'h100);
    @(negedge clk); irq_in[40] = 1'b0; #1;
    chk("R7 level drop removes request", irq_req[40], 0);
    rd(10'h0A1, rv); chk("R3 pending word after drop", rv, 0);
  endtask

  task automatic t_edge;
    wr(10'h041, 32'h000C_0000);     // enable sources 50 and 51
    @(negedge clk); irq_in[50] = 1'b0;
    @(negedge clk); irq_in[50] = 1'b1;
    @(negedge clk); irq_in[50] = 1'b0; #1;
    chk("R8 rising pulse latched", irq_req[50], 1);
    wr(10'h0A1, 32'h0004_0000); #1;
    chk("R8 clear-pending removes edge", irq_req[50], 0);
    @(negedge clk); irq_in[50] = 1'b1;
    @(negedge clk); irq_in[50] = 1'b0; ack_valid = 1'b1; ack_id = 6'd50;
    @(negedge clk); ack_valid = 1'b0; #1;
    chk("R8 acknowledge removes edge", irq_req[50], 0);
    @(negedge clk); irq_in[50] = 1'b1;
    bus_we = 1'b1; bus_addr = 10'h0A1; bus_wdata = 32'h0004_0000;
    @(negedge clk); bus_we = 1'b0; #1;
    chk("R8 edge beats clear in same cycle", irq_req[50], 1);
    @(negedge clk); irq_in[50] = 1'b0;
    wr(10'h0A1, 32'h0004_0000);
    @(negedge clk); irq_in[51] = 1'b0; #1;
    chk("R8 falling edge not yet latched", irq_req[51], 0);
    @(negedge clk); #1;
    chk("R8 falling edge latched on active-low", irq_req[51], 1);
    irq_in[51] = 1'b1;
    wr(10'h0A1, 32'h0008_0000);
    wr(10'h061, 32'h000C_0000);
    chk("R8 edge sources quiet", irq_req, 0);
  endtask

  task automatic t_swi;
    rd(10'h080, rv); chk("R9 no pending before software write", rv, 0);
    wr(10'h3C0, 32'h0001_0005);
    rd(10'h080, rv); chk("R9 software interrupt sets id 5", rv, 32'h20);
    wr(10'h3C0, 32'h0000_0006);
    rd(10'h080, rv); chk("R9 empty target list ignored", rv, 32'h20);
    wr(10'h3C0, 32'h0010_0007);
    rd(10'h080, rv); chk("R9 target bit beyond CPU count ignored", rv, 32'h20);
    rd(10'h3C0, rv); chk("R9 software register reads zero", rv, 0);
  endtask

  task automatic t_route;
    wr(10'h181, 32'h0000_0400);   // source 5 targets CPU 2
    wr(10'h040, 32'h0000_0020);
    #1;
    chk("R10 irq_req only source 5", irq_req, 64'h20);
    chk("R10 cpu_hit targets CPU 2", cpu_hit, 4'b0100);
    wr(10'h000, 32'h0); #1;
    chk("R6 distribution off clears cpu_hit", cpu_hit, 0);
    @(negedge clk); ack_valid = 1'b1; ack_id = 6'd5;
    @(negedge clk); ack_valid = 1'b0;
    rd(10'h0A0, rv); chk("R3 acknowledged software source not pending", rv, 0);
    wr(10'h081, 32'h0000_0200);
    rd(10'h0A1, rv); chk("R3 set-pending on level source", rv, 32'h200);
    wr(10'h0A1, 32'h0000_0200);
    rd(10'h081, rv); chk("R3 clear-pending", rv, 0);
  endtask

  task automatic t_bus;
    rd(10'h3FF, rv); chk("R11 unimplemented address", rv, 0);
    rd(10'h042, rv); chk("R11 enable word beyond sources", rv, 0);
    rd(10'h001, rv);
    @(negedge clk); @(negedge clk);
    chk("R11 read data holds", bus_rdata, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_enable();
    t_bytes();
    t_cfg();
    t_level();
    t_edge();
    t_swi();
    t_route();
    t_bus();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule